// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block watches the running calendar time and raises an alarm when it reaches a time the host has set. It holds two independent alarm units. Each unit stores a target second, minute, hour, day-of-week, date and month, and an enable bit for each of those six fields. A field whose enable bit is clear takes no part in the comparison. Setting only the second field therefore gives one alarm per minute, and setting only the day-of-week field gives an alarm on every tick of a chosen weekday.

The calendar core presents its current fields together with a one-cycle strobe in the cycle after it updates them. The alarm units compare only in strobe cycles, so each qualifying second produces at most one event. An event sets a sticky flag for that unit. The host reads the flag by polling and clears it with a write-one-to-clear strobe. A unit can also pull a shared active-low interrupt line low while its flag is set.

When a unit is not in repeat mode, it disarms after it fires and stays silent until the host writes any of its registers. In repeat mode the unit stays armed and fires on every second that matches. The host can read the time while this happens, and the reads do not touch this block.

Top module: `dual_alarm_match`

## Requirements
- R1: After reset both flags read 0, `irq_n` reads 1, and both units are disarmed: a strobe with every time field at zero sets no flag.
- R2: A write with `wr_en`=1 goes to the unit chosen by `wr_sel`. The `wr_field` codes are 0 second, 1 minute, 2 hour, 3 day-of-week, 4 date, 5 month and 6 control. Control bits 0 to 5 enable the field with the same code, bit 6 selects repeat mode and bit 7 enables the interrupt.
- R3: A unit compares only in a cycle with `sec_tick`=1. A match sets its flag, which becomes visible in the following cycle. A match of the time fields with no strobe sets nothing.
- R4: Fields whose enable bit is 0 are left out of the comparison. With all six enables at 0, every strobe is a match.
- R5: A flag stays set until a cycle with `clr_en`=1 and the corresponding `clr_mask` bit at 1, where bit i clears unit i. A clear aimed only at the other unit leaves the flag unchanged.
- R6: If a match and a clear of the same unit fall in the same cycle, the flag ends up set.
- R7: `irq_n` is 0 exactly while some unit has both its flag and its interrupt enable set. A flag whose unit has the interrupt enable at 0 can only be seen by polling.
- R8: With repeat mode off, a unit that fires ignores later matches until any register of that unit is written, and that write re-arms it.
- R9: With repeat mode on, a unit fires on every matching strobe without any rewrite.
- R10: The two units keep separate targets, flags and arming state. A match or write in one unit has no effect on the flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, high in the cycle after the time fields update |
| cur_sec | input | 8 | Current second |
| cur_min | input | 8 | Current minute |
| cur_hour | input | 8 | Current hour |
| cur_dow | input | 8 | Current day of week |
| cur_date | input | 8 | Current date |
| cur_month | input | 8 | Current month |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 1 | Selects the unit to write |
| wr_field | input | 3 | Selects the register to write (codes in R2) |
| wr_data | input | 8 | Write data |
| clr_en | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Flags to clear, one bit per unit |
| alarm_flag | output | 2 | Sticky alarm flags, one per unit |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
A match that sets a flag and a host clear of that same flag can land in the same cycle. The bench provokes this by driving the clear strobe in the same cycle as a matching second strobe for a unit in repeat mode whose flag is already set, and it expects the flag to stay at 1 (set has priority). It then repeats the clear on a strobe that does not match and expects the flag to drop. A second overlap checks that a unit that has just fired ignores a match that arrives before it is rewritten, and that a control write re-arms it for the next strobe.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FLD_CODE_W = 3;

  typedef enum logic [FLD_CODE_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_CTRL  = 3'd6
  } fld_code_e;

  localparam int CTRL_REPEAT_BIT = 6;
  localparam int CTRL_INTEN_BIT  = 7;
  localparam int CTRL_MIN_W      = 8;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import alm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NUM_FIELDS-1:0][DW-1:0] live_fields,
  input  logic [NUM_FIELDS-1:0][DW-1:0] tgt_fields,
  input  logic [NUM_FIELDS-1:0]         fld_en,
  output logic                          all_hit
);
  logic [NUM_FIELDS-1:0] fld_ok;

  // A field passes when it is masked out or equals its target.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign fld_ok[g] = ~fld_en[g] | (live_fields[g] == tgt_fields[g]);
  end

  assign all_hit = &fld_ok;
endmodule

// File: rtl/alm_unit.sv
module alm_unit
  import alm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sec_tick,
  input  logic [NUM_FIELDS-1:0][DW-1:0] live_fields,
  input  logic                          wr_hit,
  input  logic [FLD_CODE_W-1:0]         wr_field,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          clr_hit,
  output logic                          flag,
  output logic                          int_en
);
  logic [NUM_FIELDS-1:0][DW-1:0] tgt_q, tgt_d;
  logic [NUM_FIELDS-1:0]         en_q, en_d;
  logic                          rep_q, rep_d;
  logic                          inten_q, inten_d;
  logic                          armed_q, armed_d;
  logic                          flag_q, flag_d;
  logic                          all_hit;
  logic                          fire;
  logic                          ctrl_wr;

  alm_field_cmp #(.DW(DW)) u_cmp (
    .live_fields (live_fields),
    .tgt_fields  (tgt_q),
    .fld_en      (en_q),
    .all_hit     (all_hit)
  );

  assign ctrl_wr = wr_hit && (wr_field == FLD_CTRL);
  assign fire    = sec_tick && armed_q && all_hit;

  // Target field next state, one write decode per field.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_tgt
    always_comb begin
      tgt_d[g] = tgt_q[g];
      if (wr_hit && (wr_field == FLD_CODE_W'(g))) begin
        tgt_d[g] = wr_data;
      end
    end
  end

  always_comb begin
    en_d    = en_q;
    rep_d   = rep_q;
    inten_d = inten_q;
    if (ctrl_wr) begin
      en_d    = wr_data[NUM_FIELDS-1:0];
      rep_d   = wr_data[CTRL_REPEAT_BIT];
      inten_d = wr_data[CTRL_INTEN_BIT];
    end
  end

  // Any register write re-arms; a one-shot fire disarms.
  always_comb begin
    armed_d = armed_q;
    if (wr_hit) begin
      armed_d = 1'b1;
    end else if (fire && !rep_q) begin
      armed_d = 1'b0;
    end
  end

  // Set has priority over clear.
  always_comb begin
    flag_d = flag_q;
    if (fire) begin
      flag_d = 1'b1;
    end else if (clr_hit) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      en_q    <= '0;
      rep_q   <= 1'b0;
      inten_q <= 1'b0;
    end else if (wr_hit) begin
      tgt_q   <= tgt_d;
      en_q    <= en_d;
      rep_q   <= rep_d;
      inten_q <= inten_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign flag   = flag_q;
  assign int_en = inten_q;
endmodule

// File: rtl/alm_irq_merge.sv
module alm_irq_merge #(
  parameter int NUM_ALM = 2
) (
  input  logic [NUM_ALM-1:0] flags,
  input  logic [NUM_ALM-1:0] int_en,
  output logic               irq_n
);
  logic [NUM_ALM-1:0] req;

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_req
    assign req[g] = flags[g] & int_en[g];
  end

  assign irq_n = ~(|req);
endmodule

// File: rtl/dual_alarm_match.sv
module dual_alarm_match
  import alm_pkg::*;
#(
  parameter int NUM_ALM = 2,
  parameter int DW      = 8,
  localparam int SELW   = (NUM_ALM > 1) ? $clog2(NUM_ALM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_tick,
  input  logic [DW-1:0]         cur_sec,
  input  logic [DW-1:0]         cur_min,
  input  logic [DW-1:0]         cur_hour,
  input  logic [DW-1:0]         cur_dow,
  input  logic [DW-1:0]         cur_date,
  input  logic [DW-1:0]         cur_month,
  input  logic                  wr_en,
  input  logic [SELW-1:0]       wr_sel,
  input  logic [FLD_CODE_W-1:0] wr_field,
  input  logic [DW-1:0]         wr_data,
  input  logic                  clr_en,
  input  logic [NUM_ALM-1:0]    clr_mask,
  output logic [NUM_ALM-1:0]    alarm_flag,
  output logic                  irq_n
);
  logic [NUM_FIELDS-1:0][DW-1:0] live_fields;
  logic [NUM_ALM-1:0]            unit_inten;

  assign live_fields[FLD_SEC]   = cur_sec;
  assign live_fields[FLD_MIN]   = cur_min;
  assign live_fields[FLD_HOUR]  = cur_hour;
  assign live_fields[FLD_DOW]   = cur_dow;
  assign live_fields[FLD_DATE]  = cur_date;
  assign live_fields[FLD_MONTH] = cur_month;

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_unit
    logic wr_hit;
    logic clr_hit;
    assign wr_hit  = wr_en && (wr_sel == SELW'(g));
    assign clr_hit = clr_en && clr_mask[g];

    alm_unit #(.DW(DW)) u_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_tick    (sec_tick),
      .live_fields (live_fields),
      .wr_hit      (wr_hit),
      .wr_field    (wr_field),
      .wr_data     (wr_data),
      .clr_hit     (clr_hit),
      .flag        (alarm_flag[g]),
      .int_en      (unit_inten[g])
    );
  end

  alm_irq_merge #(.NUM_ALM(NUM_ALM)) u_irq (
    .flags  (alarm_flag),
    .int_en (unit_inten),
    .irq_n  (irq_n)
  );
endmodule

// File: rtl/alm_chk.sv
module alm_chk #(
  parameter int NUM_ALM = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               clr_en,
  input logic [NUM_ALM-1:0] clr_mask,
  input logic [NUM_ALM-1:0] alarm_flag,
  input logic               irq_n
);
  for (genvar g = 0; g < NUM_ALM; g++) begin : g_a
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag[g]) |-> $past(sec_tick)); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_mask[g] && !sec_tick) |=> !alarm_flag[g]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag[g] && !(clr_en && clr_mask[g])) |=> alarm_flag[g]); // R5
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (alarm_flag != '0)); // R7
endmodule

bind dual_alarm_match alm_chk #(.NUM_ALM(NUM_ALM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .clr_en     (clr_en),
  .clr_mask   (clr_mask),
  .alarm_flag (alarm_flag),
  .irq_n      (irq_n)
);

// File: tb/tb_dual_alarm_match.sv
module tb_dual_alarm_match;
  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_dow, cur_date, cur_month;
  logic       wr_en;
  logic [0:0] wr_sel;
  logic [2:0] wr_field;
  logic [7:0] wr_data;
  logic       clr_en;
  logic [1:0] clr_mask;
  logic [1:0] alarm_flag;
  logic       irq_n;

  int checks;
  int fails;

  dual_alarm_match dut (
    .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick),
    .cur_sec (cur_sec), .cur_min (cur_min), .cur_hour (cur_hour),
    .cur_dow (cur_dow), .cur_date (cur_date), .cur_month (cur_month),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_field (wr_field), .wr_data (wr_data),
    .clr_en (clr_en), .clr_mask (clr_mask),
    .alarm_flag (alarm_flag), .irq_n (irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] fld, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_field = fld; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_alarm(input logic sel, input logic [7:0] s, m, h, dw, dt, mo, ctl);
    wr(sel, 3'd0, s);  wr(sel, 3'd1, m);  wr(sel, 3'd2, h);
    wr(sel, 3'd3, dw); wr(sel, 3'd4, dt); wr(sel, 3'd5, mo);
    wr(sel, 3'd6, ctl);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo);
    cur_sec = s; cur_min = m; cur_hour = h; cur_dow = dw; cur_date = dt; cur_month = mo;
  endtask

  // Strobe one second with optional clear in the same cycle; result visible after.
  task automatic tick(input logic [7:0] s, m, h, dw, dt, mo, input logic [1:0] clr);
    set_time(s, m, h, dw, dt, mo);
    sec_tick = 1'b1; clr_en = (clr != 2'b00); clr_mask = clr;
    @(negedge clk);
    sec_tick = 1'b0; clr_en = 1'b0; clr_mask = 2'b00;
  endtask

  task automatic clear(input logic [1:0] m);
    clr_en = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_en = 1'b0; clr_mask = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 flags after reset", alarm_flag, 2'b00);
    chk("R1 irq_n after reset", irq_n, 1'b1);
    tick(8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 2'b00);
    chk("R1 unarmed units ignore zero-time tick", alarm_flag, 2'b00);
  endtask

  task automatic t_full_match;
    // all six fields enabled, interrupt on, repeat off
    set_alarm(1'b0, 8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h03, 8'hBF);
    tick(8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h04, 2'b00);
    chk("R4 enabled month mismatch blocks", alarm_flag, 2'b00);
    set_time(8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h03);
    repeat (3) @(negedge clk);
    chk("R3 match without tick ignored", alarm_flag, 2'b00);
    tick(8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h03, 2'b00);
    chk("R3 R2 full match sets flag0", alarm_flag, 2'b01);
    chk("R7 irq_n low with int enabled", irq_n, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 flag sticky", alarm_flag, 2'b01);
    clear(2'b10);
    chk("R5 clear of other unit leaves flag0", alarm_flag, 2'b01);
    clear(2'b01);
    chk("R5 clear drops flag0", alarm_flag, 2'b00);
    chk("R7 irq_n released", irq_n, 1'b1);
    tick(8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h03, 2'b00);
    chk("R8 one-shot disarmed after fire", alarm_flag, 2'b00);
    wr(1'b0, 3'd6, 8'hBF);
    tick(8'h30, 8'h15, 8'h05, 8'h02, 8'h21, 8'h03, 2'b00);
    chk("R8 rewrite re-arms", alarm_flag, 2'b01);
    clear(2'b01);
  endtask

  task automatic t_every_minute;
    // unit1: only second enabled, repeat on, interrupt off
    set_alarm(1'b1, 8'h00, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77, 8'h41);
    tick(8'h00, 8'h01, 8'h10, 8'h05, 8'h11, 8'h09, 2'b00);
    chk("R4 R10 masked fields ignored, unit1 only", alarm_flag, 2'b10);
    chk("R7 polled flag leaves irq high", irq_n, 1'b1);
    clear(2'b10);
    tick(8'h00, 8'h02, 8'h10, 8'h05, 8'h11, 8'h09, 2'b00);
    chk("R9 repeat fires again next minute", alarm_flag, 2'b10);
    // collision: match and clear in same cycle
    tick(8'h00, 8'h03, 8'h10, 8'h05, 8'h11, 8'h09, 2'b10);
    chk("R6 set wins over clear", alarm_flag, 2'b10);
    tick(8'h07, 8'h03, 8'h10, 8'h05, 8'h11, 8'h09, 2'b10);
    chk("R6 clear on non-matching tick", alarm_flag, 2'b00);
  endtask

  task automatic t_all_masked;
    // unit0: no fields enabled, repeat on, interrupt on
    wr(1'b0, 3'd6, 8'hC0);
    tick(8'h12, 8'h34, 8'h01, 8'h01, 8'h01, 8'h01, 2'b00);
    chk("R4 empty mask matches every tick", alarm_flag[0], 1'b1);
    chk("R7 irq with unit0", irq_n, 1'b0);
    tick(8'h13, 8'h34, 8'h01, 8'h01, 8'h01, 8'h01, 2'b01);
    chk("R9 R6 next second still set", alarm_flag[0], 1'b1);
    wr(1'b0, 3'd6, 8'h3F);
    clear(2'b11);
    chk("R5 clear both", alarm_flag, 2'b00);
    chk("R7 irq released", irq_n, 1'b1);
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; sec_tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_field = '0;
    wr_data = '0; clr_en = 1'b0; clr_mask = '0;
    set_time(8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_match();
    t_every_minute();
    t_all_masked();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule